// File: doc/BRIEF.md
# ECC Error Capture and Interrupt Unit

This block sits next to the error checker of a memory controller. The checker reports two kinds of event, corrected and uncorrected. Each event arrives as a one-cycle pulse with the failing 36-bit address, the 64-bit data word, an 8-bit syndrome and a 13-bit requester ID. The unit keeps a separate set of read-only capture registers for each kind of event. It records a first event and a repeated event as different status bits. It drives one interrupt line, and a mask register can gate each status bit out of that line.

Software reaches the unit over a simple 32-bit register bus with an address, a write enable, write data and combinational read data. To clear status bits, software writes ones to an acknowledge register. Events are counted only after software sets the enable bit in the control register.

Top module: `ecc_capture_unit`

## Requirements
- R1: After reset, all status bits are 0, all capture words read 0, the enable bit reads 0, mask bits 6:3 read 1 (mask register 0x220 = 0x78), and the interrupt is low.
- R2: Bit 16 of the control register at 0x174 is writable and reads back. While it is 0, event pulses change no status bit and no capture word.
- R3: With the enable bit set, a corrected pulse while status bit 3 is clear sets bit 3 at the next clock edge and captures that pulse's fields. The same applies to an uncorrected pulse and status bit 5. The status register is at 0x210.
- R4: A pulse that arrives while its class's first-event bit is set has two effects. It sets the second-event bit (bit 4 for corrected, bit 6 for uncorrected), and it leaves that class's capture words unchanged.
- R5: Capture layout. The corrected words are at 0x190, 0x194, 0x198 and 0x19C. The uncorrected words are at 0x180, 0x184, 0x188 and 0x18C. In each set, the first word holds address bits 31:0. The second word holds address bits 35:32 in bits 3:0 and the syndrome in bits 15:8. The third word holds data bits 31:0, and the fourth holds data bits 63:32.
- R6: The word at 0x1A0 holds the uncorrected requester ID in bits 12:0 and the corrected requester ID in bits 28:16. All other bits read 0.
- R7: Writing the acknowledge register at 0x218 clears each status bit written as 1, and bits written as 0 have no effect. The register reads 0. If an enabled event and an acknowledge hit the same bit in the same cycle, the event wins.
- R8: Mask register bits 6:3 are writable and read back, and its other bits read 0. The interrupt is high exactly when some status bit in 6:3 is set and its mask bit is 0.
- R9: Writes to the status register and to the capture words have no effect.
- R10: Once its first-event bit has been cleared, a class captures the fields of its next event again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 12 | Register byte address |
| regWe | input | 1 | Write enable |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data (combinational from regAddr) |
| ceEvt | input | 1 | Corrected event pulse |
| ceAddr | input | 36 | Corrected event address |
| ceData | input | 64 | Corrected event data |
| ceSynd | input | 8 | Corrected event syndrome |
| ceId | input | 13 | Corrected event requester ID |
| ueEvt | input | 1 | Uncorrected event pulse |
| ueAddr | input | 36 | Uncorrected event address |
| ueData | input | 64 | Uncorrected event data |
| ueSynd | input | 8 | Uncorrected event syndrome |
| ueId | input | 13 | Uncorrected event requester ID |
| irq | output | 1 | Interrupt, masked OR of status bits 6:3 |

## Verification
The assertions are checked on every cycle. They check that a second-event bit can rise only while its first-event bit is already set. They check that no first-event bit rises while the enable bit is clear, and that an acknowledge clears a first-event bit unless an enabled event hits the same bit. They also check that a capture strobe loads the incoming syndrome and address. Only the bench scenarios can show the rest: the exact register layout, the packing of the ID word, that writes to read-only words are ignored, that a repeat event leaves the captured words unchanged, that a class recaptures after an acknowledge, and the interrupt level for every combination of mask and status.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int BUS_AW     = 12;
  localparam int BUS_DW     = 32;
  localparam int ERR_AW     = 36;
  localparam int ERR_DW     = 64;
  localparam int SYND_W     = 8;
  localparam int REQ_ID_W   = 13;
  localparam int NUM_CLASS  = 2;
  localparam int CLS_CE     = 0;
  localparam int CLS_UE     = 1;
  localparam int ST_W       = 2 * NUM_CLASS;
  localparam int ST_LSB     = 3;
  localparam int EN_BIT     = 16;
  localparam int ID_UE_LSB  = 0;
  localparam int ID_CE_LSB  = 16;

  localparam logic [BUS_AW-1:0] OFS_CTRL    = 12'h174;
  localparam logic [BUS_AW-1:0] OFS_UE_BASE = 12'h180;
  localparam logic [BUS_AW-1:0] OFS_CE_BASE = 12'h190;
  localparam logic [BUS_AW-1:0] OFS_REQ_ID  = 12'h1A0;
  localparam logic [BUS_AW-1:0] OFS_STATUS  = 12'h210;
  localparam logic [BUS_AW-1:0] OFS_ACK     = 12'h218;
  localparam logic [BUS_AW-1:0] OFS_MASK    = 12'h220;

  typedef struct packed {
    logic [NUM_CLASS-1:0] capture;
  } capStrobeT;
endpackage

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl
  import ecc_cap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [BUS_AW-1:0]    regAddr,
  input  logic                 regWe,
  input  logic [BUS_DW-1:0]    regWdata,
  input  logic [NUM_CLASS-1:0] evtIn,
  output capStrobeT            strobe,
  output logic [BUS_DW-1:0]    ctrlRdata,
  output logic                 irq
);
  logic            eccEnQ;
  logic [ST_W-1:0] stQ;
  logic [ST_W-1:0] maskQ;
  logic [ST_W-1:0] setBits;
  logic [ST_W-1:0] ackBits;
  logic [ST_W-1:0] stD;
  logic [NUM_CLASS-1:0] capVec;
  logic            ackHit;

  assign ackHit  = regWe && (regAddr == OFS_ACK);
  assign ackBits = ackHit ? regWdata[ST_LSB +: ST_W] : '0;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    logic evtOk;
    assign evtOk          = evtIn[c] & eccEnQ;
    assign capVec[c]      = evtOk & ~stQ[2*c];
    assign setBits[2*c]   = evtOk & ~stQ[2*c];
    assign setBits[2*c+1] = evtOk & stQ[2*c];

    // R4
    second_needs_first_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(stQ[2*c+1]) |-> $past(stQ[2*c]));
    // R2
    disabled_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
      !eccEnQ |=> !$rose(stQ[2*c]));
    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ackHit && regWdata[ST_LSB+2*c] && !(evtIn[c] && eccEnQ)) |=> !stQ[2*c]);
  end

  assign strobe.capture = capVec;
  assign stD = (stQ & ~ackBits) | setBits;
  assign irq = |(stQ & ~maskQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eccEnQ <= 1'b0;
      stQ    <= '0;
      maskQ  <= '1;
    end else begin
      stQ <= stD;
      if (regWe && regAddr == OFS_CTRL) eccEnQ <= regWdata[EN_BIT];
      if (regWe && regAddr == OFS_MASK) maskQ  <= regWdata[ST_LSB +: ST_W];
    end
  end

  always_comb begin
    ctrlRdata = '0;
    case (regAddr)
      OFS_CTRL:   ctrlRdata[EN_BIT]          = eccEnQ;
      OFS_STATUS: ctrlRdata[ST_LSB +: ST_W]  = stQ;
      OFS_MASK:   ctrlRdata[ST_LSB +: ST_W]  = maskQ;
      default:    ctrlRdata = '0;
    endcase
  end
endmodule

// File: rtl/ecc_cap_data.sv
module ecc_cap_data
  import ecc_cap_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  capStrobeT           strobe,
  input  logic [BUS_AW-1:0]   regAddr,
  input  logic [ERR_AW-1:0]   addrIn [NUM_CLASS],
  input  logic [ERR_DW-1:0]   dataIn [NUM_CLASS],
  input  logic [SYND_W-1:0]   syndIn [NUM_CLASS],
  input  logic [REQ_ID_W-1:0] idIn   [NUM_CLASS],
  output logic [BUS_DW-1:0]   dataRdata
);
  localparam int HI_AW = ERR_AW - BUS_DW;

  logic [ERR_AW-1:0]   capAddrQ [NUM_CLASS];
  logic [ERR_DW-1:0]   capDataQ [NUM_CLASS];
  logic [SYND_W-1:0]   capSyndQ [NUM_CLASS];
  logic [REQ_ID_W-1:0] capIdQ   [NUM_CLASS];
  logic [BUS_DW-1:0]   clsRd    [NUM_CLASS];
  logic [BUS_DW-1:0]   idWord;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cap
    localparam logic [BUS_AW-1:0] BASE = (c == CLS_CE) ? OFS_CE_BASE : OFS_UE_BASE;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        capAddrQ[c] <= '0;
        capDataQ[c] <= '0;
        capSyndQ[c] <= '0;
        capIdQ[c]   <= '0;
      end else if (strobe.capture[c]) begin
        capAddrQ[c] <= addrIn[c];
        capDataQ[c] <= dataIn[c];
        capSyndQ[c] <= syndIn[c];
        capIdQ[c]   <= idIn[c];
      end
    end

    always_comb begin
      clsRd[c] = '0;
      if (regAddr == BASE)
        clsRd[c] = capAddrQ[c][BUS_DW-1:0];
      else if (regAddr == BASE + 12'h4) begin
        clsRd[c][HI_AW-1:0]  = capAddrQ[c][ERR_AW-1:BUS_DW];
        clsRd[c][8 +: SYND_W] = capSyndQ[c];
      end else if (regAddr == BASE + 12'h8)
        clsRd[c] = capDataQ[c][BUS_DW-1:0];
      else if (regAddr == BASE + 12'hC)
        clsRd[c] = capDataQ[c][ERR_DW-1:BUS_DW];
    end

    // R3
    capture_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.capture[c] |=> (capSyndQ[c] == $past(syndIn[c])) && (capAddrQ[c] == $past(addrIn[c])));
  end

  always_comb begin
    idWord = '0;
    idWord[ID_UE_LSB +: REQ_ID_W] = capIdQ[CLS_UE];
    idWord[ID_CE_LSB +: REQ_ID_W] = capIdQ[CLS_CE];
  end

  always_comb begin
    dataRdata = (regAddr == OFS_REQ_ID) ? idWord : '0;
    for (int c = 0; c < NUM_CLASS; c++) dataRdata = dataRdata | clsRd[c];
  end
endmodule

// File: rtl/ecc_capture_unit.sv
module ecc_capture_unit
  import ecc_cap_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [BUS_AW-1:0]   regAddr,
  input  logic                regWe,
  input  logic [BUS_DW-1:0]   regWdata,
  output logic [BUS_DW-1:0]   regRdata,
  input  logic                ceEvt,
  input  logic [ERR_AW-1:0]   ceAddr,
  input  logic [ERR_DW-1:0]   ceData,
  input  logic [SYND_W-1:0]   ceSynd,
  input  logic [REQ_ID_W-1:0] ceId,
  input  logic                ueEvt,
  input  logic [ERR_AW-1:0]   ueAddr,
  input  logic [ERR_DW-1:0]   ueData,
  input  logic [SYND_W-1:0]   ueSynd,
  input  logic [REQ_ID_W-1:0] ueId,
  output logic                irq
);
  capStrobeT            strobe;
  logic [BUS_DW-1:0]    ctrlRdata;
  logic [BUS_DW-1:0]    dataRdata;
  logic [NUM_CLASS-1:0] evtVec;
  logic [ERR_AW-1:0]    addrArr [NUM_CLASS];
  logic [ERR_DW-1:0]    dataArr [NUM_CLASS];
  logic [SYND_W-1:0]    syndArr [NUM_CLASS];
  logic [REQ_ID_W-1:0]  idArr   [NUM_CLASS];

  assign evtVec[CLS_CE]  = ceEvt;
  assign evtVec[CLS_UE]  = ueEvt;
  assign addrArr[CLS_CE] = ceAddr;
  assign addrArr[CLS_UE] = ueAddr;
  assign dataArr[CLS_CE] = ceData;
  assign dataArr[CLS_UE] = ueData;
  assign syndArr[CLS_CE] = ceSynd;
  assign syndArr[CLS_UE] = ueSynd;
  assign idArr[CLS_CE]   = ceId;
  assign idArr[CLS_UE]   = ueId;

  ecc_cap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .evtIn(evtVec), .strobe(strobe), .ctrlRdata(ctrlRdata), .irq(irq)
  );

  ecc_cap_data u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .addrIn(addrArr), .dataIn(dataArr), .syndIn(syndArr), .idIn(idArr),
    .dataRdata(dataRdata)
  );

  assign regRdata = ctrlRdata | dataRdata;
endmodule

// File: tb/ecc_capture_unit_bench.sv
`timescale 1ns/1ps
module ecc_capture_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        ceEvt = 1'b0, ueEvt = 1'b0;
  logic [35:0] ceAddr = '0, ueAddr = '0;
  logic [63:0] ceData = '0, ueData = '0;
  logic [7:0]  ceSynd = '0, ueSynd = '0;
  logic [12:0] ceId = '0, ueId = '0;
  logic        irq;
  int          errors = 0;
  int          checks = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  ecc_capture_unit u_ecc_capture_unit (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .ceEvt(ceEvt), .ceAddr(ceAddr), .ceData(ceData),
    .ceSynd(ceSynd), .ceId(ceId), .ueEvt(ueEvt), .ueAddr(ueAddr), .ueData(ueData),
    .ueSynd(ueSynd), .ueId(ueId), .irq(irq)
  );

  // {mask[6:3], expected irq} with status bits 3 and 5 set
  localparam logic [4:0] MASK_VEC [8] = '{
    5'b1111_0, 5'b0000_1, 5'b1110_1, 5'b1101_0,
    5'b1011_1, 5'b0111_0, 5'b1010_1, 5'b0101_0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic fire(input bit ue, input logic [35:0] a, input logic [63:0] d,
                      input logic [7:0] s, input logic [12:0] id);
    @(negedge clk);
    if (ue) begin ueEvt = 1; ueAddr = a; ueData = d; ueSynd = s; ueId = id; end
    else    begin ceEvt = 1; ceAddr = a; ceData = d; ceSynd = s; ceId = id; end
    @(negedge clk);
    ceEvt = 0; ueEvt = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(12'h210, v); check("R1 status", v, 32'h0);
    rd(12'h220, v); check("R1 mask", v, 32'h78);
    rd(12'h174, v); check("R1 enable", v, 32'h0);
    rd(12'h190, v); check("R1 capture", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    // R2 disabled events ignored
    fire(0, 36'hF_FFFF_FFFF, 64'h1, 8'hFF, 13'h1FFF);
    rd(12'h210, v); check("R2 disabled status", v, 32'h0);
    rd(12'h190, v); check("R2 disabled capture", v, 32'h0);
    wr(12'h174, 32'h0001_0000);
    rd(12'h174, v); check("R2 enable readback", v, 32'h0001_0000);
    // R3 first corrected event
    fire(0, 36'hA_1234_5678, 64'hDEADBEEF_CAFEF00D, 8'h5A, 13'h1ABC);
    rd(12'h210, v); check("R3 ce status", v, 32'h08);
    check("R8 masked irq", {31'b0, irq}, 32'h0);
    rd(12'h190, v); check("R5 ce addr lo", v, 32'h1234_5678);
    rd(12'h194, v); check("R5 ce addr hi/synd", v, 32'h0000_5A0A);
    rd(12'h198, v); check("R5 ce data lo", v, 32'hCAFE_F00D);
    rd(12'h19C, v); check("R5 ce data hi", v, 32'hDEAD_BEEF);
    rd(12'h1A0, v); check("R6 id ce only", v, 32'h1ABC_0000);
    // R4 repeat corrected event
    fire(0, 36'h1_1111_1111, 64'h2, 8'h11, 13'h0001);
    rd(12'h210, v); check("R4 second ce", v, 32'h18);
    rd(12'h190, v); check("R4 capture held", v, 32'h1234_5678);
    rd(12'h194, v); check("R4 synd held", v, 32'h0000_5A0A);
    // R3 uncorrected
    fire(1, 36'h3_0000_0042, 64'h01234567_89ABCDEF, 8'hC3, 13'h0155);
    rd(12'h210, v); check("R3 ue status", v, 32'h38);
    rd(12'h180, v); check("R5 ue addr lo", v, 32'h0000_0042);
    rd(12'h184, v); check("R5 ue addr hi/synd", v, 32'h0000_C303);
    rd(12'h188, v); check("R5 ue data lo", v, 32'h89AB_CDEF);
    rd(12'h18C, v); check("R5 ue data hi", v, 32'h0123_4567);
    rd(12'h1A0, v); check("R6 id both", v, 32'h1ABC_0155);
    // R9 read-only registers
    wr(12'h210, 32'h0);
    wr(12'h190, 32'hFFFF_FFFF);
    rd(12'h210, v); check("R9 status write ignored", v, 32'h38);
    rd(12'h190, v); check("R9 capture write ignored", v, 32'h1234_5678);
    // R7 acknowledge
    wr(12'h218, 32'h10);
    rd(12'h210, v); check("R7 ack bit4", v, 32'h28);
    wr(12'h218, 32'h0);
    rd(12'h210, v); check("R7 zero ack no effect", v, 32'h28);
    rd(12'h218, v); check("R7 ack reads zero", v, 32'h0);
    // R8 mask table
    foreach (MASK_VEC[i]) begin
      wr(12'h220, {25'h1FFFFFF, MASK_VEC[i][4:1], 3'b111});
      rd(12'h220, v); check("R8 mask readback", v, {25'b0, MASK_VEC[i][4:1], 3'b0});
      check("R8 irq", {31'b0, irq}, {31'b0, MASK_VEC[i][0]});
    end
    // R10 recapture after ack
    wr(12'h218, 32'h08);
    rd(12'h210, v); check("R7 ack bit3", v, 32'h20);
    fire(0, 36'h5_0000_0777, 64'h0, 8'h3C, 13'h0002);
    rd(12'h210, v); check("R10 status", v, 32'h28);
    rd(12'h190, v); check("R10 recapture lo", v, 32'h0000_0777);
    rd(12'h194, v); check("R10 recapture hi", v, 32'h0000_3C05);
    // R2 disable again
    wr(12'h174, 32'h0);
    wr(12'h218, 32'h78);
    fire(1, 36'h1, 64'h1, 8'h1, 13'h1);
    rd(12'h210, v); check("R2 disabled ue", v, 32'h0);
    rd(12'h180, v); check("R2 ue capture kept", v, 32'h0000_0042);
    check("R8 irq idle", {31'b0, irq}, 32'h0);
    done = 1;
    summary();
    $finish;
  end
endmodule